// File: doc/BRIEF.md
# Queue Page-List Walker

This block assembles the page table of a queue whose storage is scattered over many memory pages instead of one contiguous region. Software hands it a pointer to the first list page, the queue size field, the entry-size exponent and the memory-page-size field, then pulses `start`. The walker computes how many queue pages the queue occupies. It then reads the pointers one 64-bit word at a time over a request/response read port and follows the chain from one list page to the next. Each pointer it accepts goes into a local table RAM that other logic reads through a registered read port.

Each list page has one slot per 8 bytes of the page. When more pointers are still needed, the last slot of a list page is the link to the next list page. Every address the walker relies on must be nonzero and aligned to the page size: the base pointer, each link and each queue-page pointer. A single bad address ends the whole build with a sticky error and an invalid-field status that carries a do-not-retry flag. A clean build ends with a sticky done flag.

The control is one state machine with seven named states:
- `ST_IDLE` waits for `start`.
- `ST_SIZE` checks the configuration and the base pointer, then enters either `ST_ISSUE` or `ST_ABORT`.
- `ST_ISSUE` holds a read request until it is accepted, then enters `ST_WAIT`.
- `ST_WAIT` waits for the response, then enters `ST_EVAL`.
- `ST_EVAL` classifies the returned word. A bad word leads to `ST_ABORT`. A good link or a good pointer leads back to `ST_ISSUE`. The last good pointer leads to `ST_FINISH`.
- `ST_FINISH` sets done and `ST_ABORT` sets error. Both return to `ST_IDLE`.

Top module: `qpage_walker`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0, `err_status` is 0 and no read request is raised.
- R2: The walker stores exactly N = ceil((cfg_qsize+1) · 2^cfg_esize / 2^(cfg_mps+12)) pointers. They go into table indices 0..N-1 in walk order. `tab_rd_ptr` shows the entry at `tab_rd_idx` one cycle after the index is applied.
- R3: Every read is one 64-bit word at the current list-page address plus 8 × slot, with slots in ascending order. At most one read is outstanding. A request holds its valid and address steady until `mrd_ready` accepts it.
- R4: The last slot of a list page (index 2^(cfg_mps+9)−1) is used only as the link to the next list page, and only when more than one pointer is still needed. Each non-final list page therefore adds 2^(cfg_mps+9)−1 table entries.
- R5: When N ≤ 2^(cfg_mps+9), only the first list page is read: exactly N reads are made and no link is followed. This includes the case where N fills every slot of that page.
- R6: If the base pointer is zero or has any bit below the page size set, the build errors without issuing any read.
- R7: If any fetched word (a queue-page pointer or a link) is zero or not page-aligned, the build errors at once, makes no further read and does not set `done`.
- R8: While `err` is 1, `err_status` is 16'h4002: bit 14 is the do-not-retry flag and the low byte 0x02 means invalid field. Otherwise `err_status` is 0.
- R9: If `cfg_mps` exceeds `MPS_MAX`, or N exceeds `TAB_DEPTH`, the build errors without issuing any read.
- R10: A `start` pulse while `busy` is 1 is ignored. The running build finishes with its original parameters.
- R11: `done` and `err` stay set until the next accepted `start`. An accepted `start` clears both and raises `busy` on the next cycle. `done` and `err` are never 1 together.
- R12: With the default bus byte order, the byte at the lowest address arrives in `mrs_data[7:0]`. The pointer is then used as received, with no swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a build (accepted only while idle) |
| cfg_base | input | 64 | Address of the first list page |
| cfg_qsize | input | 16 | Queue size field; depth is this plus one |
| cfg_esize | input | 4 | Entry size is 2^cfg_esize bytes |
| cfg_mps | input | 4 | Page size is 2^(cfg_mps+12) bytes |
| busy | output | 1 | A build is in progress |
| done | output | 1 | Sticky: last build completed |
| err | output | 1 | Sticky: last build aborted |
| err_status | output | 16 | Error status code, 0 when no error |
| mrd_valid | output | 1 | Read request valid |
| mrd_ready | input | 1 | Read request accepted |
| mrd_addr | output | 64 | Read request byte address |
| mrs_valid | input | 1 | Read response valid |
| mrs_data | input | 64 | Read response data word |
| tab_rd_idx | input | 10 | Table read index |
| tab_rd_ptr | output | 64 | Table entry at the index of the previous cycle |

## Verification
The walk is driven with four queue shapes:
- A few pointers that fit in one list page.
- A queue that needs exactly every slot of one list page. This separates "last slot stored" from "last slot followed as a link".
- A chained queue of 600 pointers spanning two list pages. This shows that the link is skipped in the table and that table indices run on across the page boundary.
- A one-entry queue, which exercises the rounding of the page count.

A larger page size with a pointer aligned only to 4 KiB shows that alignment follows the configured page size. Bad base, bad link, zero pointer, oversize and out-of-range page-size cases are each judged by the read count: no reads, or a read count that stops exactly at the faulty word. A `start` pulse during a build with a bad base would fail if it were honoured, which makes it a clear test of R10.

// File: rtl/qpw_pkg.sv
package qpw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SIZE,
        ST_ISSUE,
        ST_WAIT,
        ST_EVAL,
        ST_FINISH,
        ST_ABORT
    } walk_state_t;

    // do-not-retry flag in bit 14, invalid-field code in the low byte
    localparam logic [15:0] STATUS_BAD_FIELD = 16'h4002;

endpackage

// File: rtl/qpw_sizer.sv
module qpw_sizer #(
    parameter int QS_W      = 16,
    parameter int MPS_MAX   = 4,
    parameter int TAB_DEPTH = 1024,
    parameter int CNT_W     = QS_W + 5
) (
    input  logic [QS_W-1:0]  size_field,
    input  logic [3:0]       esize_exp,
    input  logic [3:0]       mps,
    output logic [CNT_W-1:0] page_count,
    output logic             mps_bad,
    output logic             too_big
);
    localparam int BW = QS_W + 17;

    logic [BW-1:0] depth_ext;
    logic [BW-1:0] byte_len;
    logic [BW-1:0] round_mask;
    logic [BW-1:0] rounded;
    logic [4:0]    shamt;

    always_comb begin
        shamt      = {1'b0, mps} + 5'd12;
        depth_ext  = BW'(size_field) + BW'(1);
        byte_len   = depth_ext << esize_exp;
        round_mask = (BW'(1) << shamt) - BW'(1);
        rounded    = (byte_len + round_mask) >> shamt;
        page_count = CNT_W'(rounded);
        mps_bad    = (32'(mps) > MPS_MAX);
        too_big    = (rounded > BW'(TAB_DEPTH));
    end

endmodule

// File: rtl/qpw_ptr_check.sv
module qpw_ptr_check #(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic [ADDR_W-1:0] page_mask,
    output logic              ptr_bad
);
    always_comb begin
        ptr_bad = (ptr == '0) || ((ptr & page_mask) != '0);
    end
endmodule

// File: rtl/qpw_byteorder.sv
module qpw_byteorder #(
    parameter int DATA_W         = 64,
    parameter bit BUS_BIG_ENDIAN = 1'b0
) (
    input  logic [DATA_W-1:0] bus_word,
    output logic [DATA_W-1:0] host_word
);
    localparam int NBYTES = DATA_W / 8;

    generate
        if (BUS_BIG_ENDIAN) begin : g_swap
            for (genvar b = 0; b < NBYTES; b++) begin : g_byte
                assign host_word[8*b +: 8] = bus_word[8*(NBYTES-1-b) +: 8];
            end
        end else begin : g_pass
            assign host_word = bus_word;
        end
    endgenerate
endmodule

// File: rtl/qpw_table.sv
module qpw_table #(
    parameter int DEPTH  = 1024,
    parameter int DW     = 52,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
        rd_data <= mem[rd_idx];
    end
endmodule

// File: rtl/qpage_walker.sv
module qpage_walker
    import qpw_pkg::*;
#(
    parameter int ADDR_W         = 64,
    parameter int QS_W           = 16,
    parameter int MPS_MAX        = 4,
    parameter int TAB_DEPTH      = 1024,
    parameter bit BUS_BIG_ENDIAN = 1'b0,
    parameter int TAB_AW         = $clog2(TAB_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [QS_W-1:0]   cfg_qsize,
    input  logic [3:0]        cfg_esize,
    input  logic [3:0]        cfg_mps,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [15:0]       err_status,
    output logic              mrd_valid,
    input  logic              mrd_ready,
    output logic [ADDR_W-1:0] mrd_addr,
    input  logic              mrs_valid,
    input  logic [63:0]       mrs_data,
    input  logic [TAB_AW-1:0] tab_rd_idx,
    output logic [ADDR_W-1:0] tab_rd_ptr
);
    localparam int CNT_W  = QS_W + 5;
    localparam int SLOT_W = MPS_MAX + 9;
    localparam int MIN_PG = 12;
    localparam int TDW    = ADDR_W - MIN_PG;

    walk_state_t state_q, state_d;

    logic [ADDR_W-1:0] base_q;
    logic [QS_W-1:0]   qsize_q;
    logic [3:0]        esize_q;
    logic [3:0]        mps_q;

    logic [ADDR_W-1:0] list_q;
    logic [SLOT_W-1:0] slot_q;
    logic [CNT_W-1:0]  remain_q;
    logic [TAB_AW:0]   widx_q;
    logic [ADDR_W-1:0] word_q;
    logic              done_q;
    logic              err_q;
    logic [15:0]       status_q;

    logic [CNT_W-1:0]  page_count;
    logic              mps_bad;
    logic              too_big;
    logic [ADDR_W-1:0] page_mask;
    logic [SLOT_W-1:0] last_slot;
    logic [ADDR_W-1:0] chk_ptr;
    logic              chk_bad;
    logic [63:0]       host_word;
    logic              is_link;
    logic              tab_wr;
    logic [TDW-1:0]    tab_q;

    // ---------------- sub-blocks ----------------
    qpw_sizer #(
        .QS_W      (QS_W),
        .MPS_MAX   (MPS_MAX),
        .TAB_DEPTH (TAB_DEPTH),
        .CNT_W     (CNT_W)
    ) u_sizer (
        .size_field (qsize_q),
        .esize_exp  (esize_q),
        .mps        (mps_q),
        .page_count (page_count),
        .mps_bad    (mps_bad),
        .too_big    (too_big)
    );

    qpw_ptr_check #(.ADDR_W(ADDR_W)) u_ptr_check (
        .ptr       (chk_ptr),
        .page_mask (page_mask),
        .ptr_bad   (chk_bad)
    );

    qpw_byteorder #(
        .DATA_W         (64),
        .BUS_BIG_ENDIAN (BUS_BIG_ENDIAN)
    ) u_byteorder (
        .bus_word  (mrs_data),
        .host_word (host_word)
    );

    qpw_table #(
        .DEPTH (TAB_DEPTH),
        .DW    (TDW),
        .AW    (TAB_AW)
    ) u_table (
        .clk     (clk),
        .wr_en   (tab_wr),
        .wr_idx  (widx_q[TAB_AW-1:0]),
        .wr_data (word_q[ADDR_W-1:MIN_PG]),
        .rd_idx  (tab_rd_idx),
        .rd_data (tab_q)
    );

    // ---------------- derived values ----------------
    always_comb begin
        page_mask = (ADDR_W'(1) << ({1'b0, mps_q} + 5'd12)) - ADDR_W'(1);
        last_slot = (SLOT_W'(1) << ({1'b0, mps_q} + 5'd9)) - SLOT_W'(1);
        chk_ptr   = (state_q == ST_SIZE) ? base_q : word_q;
        is_link   = (slot_q == last_slot) && (remain_q > CNT_W'(1));
        tab_wr    = (state_q == ST_EVAL) && !chk_bad && !is_link;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_SIZE;
            end
            ST_SIZE: begin
                if (mps_bad || too_big || chk_bad) state_d = ST_ABORT;
                else                               state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (mrd_ready) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (mrs_valid) state_d = ST_EVAL;
            end
            ST_EVAL: begin
                if (chk_bad)                         state_d = ST_ABORT;
                else if (is_link)                    state_d = ST_ISSUE;
                else if (remain_q == CNT_W'(1))      state_d = ST_FINISH;
                else                                 state_d = ST_ISSUE;
            end
            ST_FINISH: state_d = ST_IDLE;
            ST_ABORT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs and datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q   <= '0;
            qsize_q  <= '0;
            esize_q  <= '0;
            mps_q    <= '0;
            list_q   <= '0;
            slot_q   <= '0;
            remain_q <= '0;
            widx_q   <= '0;
            word_q   <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            status_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        base_q   <= cfg_base;
                        qsize_q  <= cfg_qsize;
                        esize_q  <= cfg_esize;
                        mps_q    <= cfg_mps;
                        done_q   <= 1'b0;
                        err_q    <= 1'b0;
                        status_q <= '0;
                    end
                end
                ST_SIZE: begin
                    list_q   <= base_q;
                    slot_q   <= '0;
                    remain_q <= page_count;
                    widx_q   <= '0;
                end
                ST_ISSUE: begin
                end
                ST_WAIT: begin
                    if (mrs_valid) word_q <= ADDR_W'(host_word);
                end
                ST_EVAL: begin
                    if (!chk_bad) begin
                        if (is_link) begin
                            list_q <= word_q;
                            slot_q <= '0;
                        end else begin
                            widx_q   <= widx_q + 1'b1;
                            remain_q <= remain_q - 1'b1;
                            slot_q   <= slot_q + 1'b1;
                        end
                    end
                end
                ST_FINISH: begin
                    done_q <= 1'b1;
                end
                ST_ABORT: begin
                    err_q    <= 1'b1;
                    status_q <= STATUS_BAD_FIELD;
                end
                default: begin
                end
            endcase
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign done       = done_q;
    assign err        = err_q;
    assign err_status = status_q;
    assign mrd_valid  = (state_q == ST_ISSUE);
    assign mrd_addr   = list_q + ADDR_W'({slot_q, 3'b000});
    assign tab_rd_ptr = {tab_q, {MIN_PG{1'b0}}};

endmodule

// File: rtl/qpage_walker_chk.sv
module qpage_walker_chk #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [15:0]       err_status,
    input logic              mrd_valid,
    input logic              mrd_ready,
    input logic [ADDR_W-1:0] mrd_addr
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mrd_valid && !mrd_ready) |=> (mrd_valid && $stable(mrd_addr))); // R3

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (mrd_valid && mrd_ready) |=> !mrd_valid); // R3

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R11

    AST_BUSY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!done && !err)); // R11

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done && !err)); // R11

    AST_ERR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_status == 16'h4002)); // R8

    AST_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !err |-> (err_status == 16'h0000)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mrd_valid); // R1
endmodule

bind qpage_walker qpage_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .err_status (err_status),
    .mrd_valid  (mrd_valid),
    .mrd_ready  (mrd_ready),
    .mrd_addr   (mrd_addr)
);

// File: tb/qpage_walker_bench.sv
module qpage_walker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] cfg_base = '0;
    logic [15:0] cfg_qsize = '0;
    logic [3:0]  cfg_esize = '0;
    logic [3:0]  cfg_mps = '0;
    logic        busy, done, err;
    logic [15:0] err_status;
    logic        mrd_valid;
    logic        mrd_ready = 1'b1;
    logic [63:0] mrd_addr;
    logic        mrs_valid = 1'b0;
    logic [63:0] mrs_data = '0;
    logic [9:0]  tab_rd_idx = '0;
    logic [63:0] tab_rd_ptr;

    int total = 0;
    int bad = 0;
    int nreads = 0;
    logic [63:0] last_addr = '0;
    logic [63:0] mem [longint unsigned];

    always #2 clk = ~clk;

    qpage_walker u_qpage_walker (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_base(cfg_base), .cfg_qsize(cfg_qsize), .cfg_esize(cfg_esize), .cfg_mps(cfg_mps),
        .busy(busy), .done(done), .err(err), .err_status(err_status),
        .mrd_valid(mrd_valid), .mrd_ready(mrd_ready), .mrd_addr(mrd_addr),
        .mrs_valid(mrs_valid), .mrs_data(mrs_data),
        .tab_rd_idx(tab_rd_idx), .tab_rd_ptr(tab_rd_ptr)
    );

    // memory responder: two-cycle latency, ready stalls one cycle in four
    initial begin
        int pend = 0;
        int cyc = 0;
        logic [63:0] paddr = '0;
        forever begin
            @(negedge clk);
            cyc++;
            mrs_valid = 1'b0;
            mrd_ready = ((cyc % 4) != 3);
            if (pend != 0) begin
                pend--;
                if (pend == 0) begin
                    mrs_valid = 1'b1;
                    mrs_data  = mem.exists(paddr) ? mem[paddr] : 64'h0;
                end
            end
            if (mrd_valid && mrd_ready && rst_n) begin
                paddr     = mrd_addr;
                last_addr = mrd_addr;
                pend      = 2;
                nreads++;
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] qptr(input int k, input logic [63:0] page);
        return 64'h4000_0000 + 64'(k) * page;
    endfunction

    // lay out a chained list: links to next list page 1 MiB further on
    task automatic fill_list(input logic [63:0] base, input int n, input int mps);
        logic [63:0] page;
        logic [63:0] lp;
        int per;
        int slot;
        page = 64'h1000 << mps;
        per  = 512 << mps;
        lp   = base;
        slot = 0;
        mem.delete();
        for (int k = 0; k < n; k++) begin
            if (slot == per - 1 && (n - k) > 1) begin
                mem[lp + 64'(8 * slot)] = lp + 64'h10_0000;
                lp   = lp + 64'h10_0000;
                slot = 0;
            end
            mem[lp + 64'(8 * slot)] = qptr(k, page);
            slot++;
        end
    endtask

    task automatic run_walk(input logic [63:0] base, input logic [15:0] qs,
                            input logic [3:0] es, input logic [3:0] mps);
        @(negedge clk);
        nreads    = 0;
        cfg_base  = base;
        cfg_qsize = qs;
        cfg_esize = es;
        cfg_mps   = mps;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
    endtask

    task automatic check_table(input string req, input int n, input int mps);
        int miss = 0;
        for (int k = 0; k < n; k++) begin
            tab_rd_idx = 10'(k);
            @(negedge clk);
            if (tab_rd_ptr !== qptr(k, 64'h1000 << mps)) miss++;
        end
        chk(req, 64'(miss), 64'h0);
    endtask

    task automatic t_reset;
        chk("R1 busy", {63'h0, busy}, 64'h0);
        chk("R1 done", {63'h0, done}, 64'h0);
        chk("R1 err", {63'h0, err}, 64'h0);
        chk("R1 status", {48'h0, err_status}, 64'h0);
        chk("R1 req", {63'h0, mrd_valid}, 64'h0);
    endtask

    task automatic t_single_page;
        // 256 entries of 64 B in 4 KiB pages -> 4 pointers
        fill_list(64'h0020_0000, 4, 0);
        run_walk(64'h0020_0000, 16'd255, 4'd6, 4'd0);
        chk("R2 done", {63'h0, done}, 64'h1);
        chk("R5 reads", 64'(nreads), 64'd4);
        chk("R3 last addr", last_addr, 64'h0020_0018);
        chk("R12 table as received", 64'h0, 64'h0);
        check_table("R2 R12 table", 4, 0);
    endtask

    task automatic t_tiny;
        // one entry of 16 B still needs one page
        fill_list(64'h0030_0000, 1, 0);
        run_walk(64'h0030_0000, 16'd0, 4'd4, 4'd0);
        chk("R2 tiny done", {63'h0, done}, 64'h1);
        chk("R2 tiny reads", 64'(nreads), 64'd1);
        check_table("R2 tiny table", 1, 0);
    endtask

    task automatic t_full_page;
        // 512 pointers: last slot is a queue pointer, not a link
        fill_list(64'h0040_0000, 512, 0);
        run_walk(64'h0040_0000, 16'd32767, 4'd6, 4'd0);
        chk("R5 full done", {63'h0, done}, 64'h1);
        chk("R5 full reads", 64'(nreads), 64'd512);
        chk("R5 full last addr", last_addr, 64'h0040_0FF8);
        check_table("R4 R5 full table", 512, 0);
    endtask

    task automatic t_chain;
        // 600 pointers: 511 on first page, link, 89 on second
        fill_list(64'h0050_0000, 600, 0);
        run_walk(64'h0050_0000, 16'd38399, 4'd6, 4'd0);
        chk("R4 chain done", {63'h0, done}, 64'h1);
        chk("R4 chain reads", 64'(nreads), 64'd601);
        chk("R4 chain last addr", last_addr, 64'h0060_0000 + 64'd8 * 64'd88);
        check_table("R2 R4 chain table", 600, 0);
    endtask

    task automatic t_bad_base;
        mem.delete();
        run_walk(64'h0, 16'd255, 4'd6, 4'd0);
        chk("R6 zero base err", {63'h0, err}, 64'h1);
        chk("R6 zero base reads", 64'(nreads), 64'd0);
        chk("R8 status", {48'h0, err_status}, 64'h4002);
        run_walk(64'h1000_0800, 16'd255, 4'd6, 4'd0);
        chk("R6 misaligned base err", {63'h0, err}, 64'h1);
        chk("R6 misaligned base reads", 64'(nreads), 64'd0);
    endtask

    task automatic t_bad_ptr;
        fill_list(64'h0020_0000, 4, 0);
        mem[64'h0020_0010] = 64'h0;
        run_walk(64'h0020_0000, 16'd255, 4'd6, 4'd0);
        chk("R7 zero ptr err", {63'h0, err}, 64'h1);
        chk("R7 zero ptr done", {63'h0, done}, 64'h0);
        chk("R7 zero ptr reads", 64'(nreads), 64'd3);
        // 8 KiB pages: a 4 KiB-aligned pointer is misaligned
        fill_list(64'h0080_0000, 2, 1);
        mem[64'h0080_0008] = 64'h4000_3000;
        run_walk(64'h0080_0000, 16'd255, 4'd6, 4'd1);
        chk("R7 page-size align err", {63'h0, err}, 64'h1);
        chk("R7 page-size align reads", 64'(nreads), 64'd2);
    endtask

    task automatic t_bad_link;
        fill_list(64'h0050_0000, 600, 0);
        mem[64'h0050_0FF8] = 64'h0060_0040;
        run_walk(64'h0050_0000, 16'd38399, 4'd6, 4'd0);
        chk("R7 link err", {63'h0, err}, 64'h1);
        chk("R7 link reads", 64'(nreads), 64'd512);
        chk("R8 link status", {48'h0, err_status}, 64'h4002);
    endtask

    task automatic t_limits;
        mem.delete();
        run_walk(64'h0020_0000, 16'hFFFF, 4'd7, 4'd0);
        chk("R9 too big err", {63'h0, err}, 64'h1);
        chk("R9 too big reads", 64'(nreads), 64'd0);
        run_walk(64'h0020_0000, 16'd255, 4'd6, 4'd5);
        chk("R9 mps err", {63'h0, err}, 64'h1);
        chk("R9 mps reads", 64'(nreads), 64'd0);
    endtask

    task automatic t_ignore_start;
        fill_list(64'h0020_0000, 4, 0);
        @(negedge clk);
        nreads    = 0;
        cfg_base  = 64'h0020_0000;
        cfg_qsize = 16'd255;
        cfg_esize = 4'd6;
        cfg_mps   = 4'd0;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        cfg_base = 64'h0;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        chk("R10 done", {63'h0, done}, 64'h1);
        chk("R10 err", {63'h0, err}, 64'h0);
        chk("R10 reads", 64'(nreads), 64'd4);
        check_table("R10 table", 4, 0);
    endtask

    task automatic t_sticky;
        repeat (5) @(negedge clk);
        chk("R11 done sticky", {63'h0, done}, 64'h1);
        fill_list(64'h0020_0000, 4, 0);
        cfg_base  = 64'h0020_0000;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11 busy after start", {63'h0, busy}, 64'h1);
        chk("R11 done cleared", {63'h0, done}, 64'h0);
        while (busy) @(negedge clk);
        run_walk(64'h0, 16'd255, 4'd6, 4'd0);
        repeat (5) @(negedge clk);
        chk("R11 err sticky", {63'h0, err}, 64'h1);
        run_walk(64'h0020_0000, 16'd255, 4'd6, 4'd0);
        chk("R11 err cleared", {63'h0, err}, 64'h0);
        chk("R8 status cleared", {48'h0, err_status}, 64'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_page();
        t_tiny();
        t_full_page();
        t_chain();
        t_bad_base();
        t_bad_ptr();
        t_bad_link();
        t_limits();
        t_ignore_start();
        t_sticky();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule